// File: doc/BRIEF.md
# Band-Scheduled Crossbar Switching Controller

This block steers an N-input by N-output multiplexer crossbar whose use is divided into time bands. A free-running cycle counter runs from zero to a programmable length minus one and wraps. A band opens when the counter matches a programmable begin value and closes when it matches an end value. During a band, each output owns a set of eligible inputs and optionally one priority input. The block looks only at these settings and at one busy line per input, and never at the data itself. From them it drives a registered multiplexer select and a valid flag for every output.

A host writes per-output staging settings at any time. All staging entries become the active configuration together at the next band opening. Inside a band, an output grants the lowest-numbered eligible busy input and keeps that grant while the input stays busy. A busy priority input takes the output at once, and the input it displaced gets a one-cycle resend request. For delay measurement the block also records the counter value at the first busy input of each line and at the first valid cycle of each output after every band opening.

Top module: `bandsw_ctrl`

## Requirements
- R1: `cyc_now` is 0 after reset and advances by one on every clock edge. After the value `cyc_len`-1 it returns to 0.
- R2: On the edge where `cyc_now` equals `band_begin`, `band_active` rises and each `out_en` bit is set to whether that output's staged input mask is non-zero. On the edge where `cyc_now` equals `band_end`, `band_active` and all `out_en` bits fall.
- R3: A configuration write (`cfg_we` with `cfg_port` selecting the output) changes only staging storage. The staging values take effect for all outputs together at the next band opening, and a write during a band leaves the running grants unchanged.
- R4: An input is eligible for an output when its mask bit is 1 and it is busy. Without a priority claim, a free output grants the lowest-index eligible input. The grant is kept while that input stays eligible, even if lower-index inputs become busy.
- R5: If an output's priority is enabled and its priority input is eligible, that input is granted at the next edge. If a different input held the output, `resend_req` bit i (i being the displaced input's index) is 1 for exactly one cycle.
- R6: An output with no grant drives `sel_vld` 0 and its 3-bit select field (bits [3o+2:3o] for output o, at 4 ports) to the idle code 7 (all ones). This holds outside bands, on band opening and closing edges, and when no input is eligible.
- R7: Each select and valid output reflects the busy inputs sampled at the preceding clock edge (one cycle of latency).
- R8: After a band opens, the first edge that sees input i busy while the band is active stores the pre-edge `cyc_now` value into `arr_ts` field i (bits [16i+15:16i]) and sets `arr_vld` bit i. Later edges leave the field unchanged until the next band opening clears the field and the bit.
- R9: After a band opens, the first edge that sees `sel_vld` bit o high stores the pre-edge `cyc_now` value into `dep_ts` field o and sets `dep_vld` bit o. The band opening clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_len | input | TS_W | Cycle length; counter wraps after cyc_len-1 |
| band_begin | input | TS_W | Counter value that opens the band |
| band_end | input | TS_W | Counter value that closes the band |
| cfg_we | input | 1 | Staging write strobe |
| cfg_port | input | IDX_W | Output whose staging entry is written |
| cfg_mask | input | N_PORTS | Eligible-input mask to stage |
| cfg_prio | input | IDX_W | Priority input index to stage |
| cfg_prio_en | input | 1 | Priority enable to stage |
| busy_in | input | N_PORTS | Per-input busy lines |
| band_active | output | 1 | Band currently open |
| out_en | output | N_PORTS | Output takes part in the open band |
| sel_out | output | N_PORTS*SEL_W | Per-output multiplexer selects |
| sel_vld | output | N_PORTS | Per-output grant valid |
| resend_req | output | N_PORTS | One-cycle pulse per displaced input |
| cyc_now | output | TS_W | Cycle counter value |
| arr_ts | output | N_PORTS*TS_W | Per-input first-arrival timestamps |
| arr_vld | output | N_PORTS | Arrival timestamp captured |
| dep_ts | output | N_PORTS*TS_W | Per-output first-departure timestamps |
| dep_vld | output | N_PORTS | Departure timestamp captured |

## Verification
A sequence of busy patterns runs through one band with three differently configured outputs. The sequence separates lowest-index selection from a held grant, a lost grant from re-arbitration, and a priority claim, with its displacement pulse, from an ordinary grant. One output has an empty mask, and another has a mask that excludes busy inputs; these show that eligibility gates every grant. Directed steps then rewrite the staging settings in the middle of a band and confirm that grants keep the old settings until the next opening. Further steps show busy lines ignored outside a band, and the timestamps cleared and captured again with known counter values in the following band.

// File: rtl/bandsw_pkg.sv
package bandsw_pkg;
  localparam int MAX_PORTS = 32;

  // Index of the lowest set bit, -1 when the vector is empty.
  function automatic int first_set(input logic [MAX_PORTS-1:0] v);
    int r;
    r = -1;
    for (int i = MAX_PORTS - 1; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/bandsw_clock.sv
module bandsw_clock #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TS_W-1:0] cyc_len,
  input  logic [TS_W-1:0] band_begin,
  input  logic [TS_W-1:0] band_end,
  output logic [TS_W-1:0] cnt,
  output logic            band_act,
  output logic            band_start,
  output logic            band_stop
);
  logic last;

  assign last       = (cnt == cyc_len - TS_W'(1));
  assign band_start = (cnt == band_begin);
  assign band_stop  = (cnt == band_end) && !band_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      band_act <= 1'b0;
    end else begin
      cnt <= last ? '0 : cnt + TS_W'(1);
      if (band_start)     band_act <= 1'b1;
      else if (band_stop) band_act <= 1'b0;
    end
  end

  // R1: wrap to zero after the last count
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (cyc_len != '0 && last) |=> (cnt == '0));
  // R2: band opens on begin match and closes on end match
  a_r2_open: assert property (@(posedge clk) disable iff (rst)
    band_start |=> band_act);
  a_r2_close: assert property (@(posedge clk) disable iff (rst)
    band_stop |=> !band_act);
endmodule

// File: rtl/bandsw_outarb.sv
module bandsw_outarb
  import bandsw_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             band_act,
  input  logic             band_start,
  input  logic             band_stop,
  input  logic [N-1:0]     busy,
  input  logic [N-1:0]     mask,
  input  logic [IDX_W-1:0] prio,
  input  logic             prio_en,
  output logic [SEL_W-1:0] sel,
  output logic             vld,
  output logic [N-1:0]     preempt
);
  localparam logic [SEL_W-1:0] IDLE = '1;

  logic [N-1:0]           elig;
  logic [MAX_PORTS-1:0]   elig_w;
  logic                   prio_hit;
  logic                   held_ok;
  logic [IDX_W-1:0]       cur;
  int                     first;

  assign elig = mask & busy;
  assign cur  = sel[IDX_W-1:0];

  always_comb begin
    elig_w          = '0;
    elig_w[N-1:0]   = elig;
    first           = first_set(elig_w);
    prio_hit        = prio_en && (int'(prio) < N) && elig[prio];
    held_ok         = vld && elig[cur];
  end

  always_ff @(posedge clk) begin
    preempt <= '0;
    if (rst || band_start || band_stop || !band_act) begin
      sel <= IDLE;
      vld <= 1'b0;
    end else if (prio_hit) begin
      sel <= {1'b0, prio};
      vld <= 1'b1;
      if (vld && cur != prio) preempt[cur] <= 1'b1;
    end else if (held_ok) begin
      sel <= sel;
      vld <= 1'b1;
    end else if (first >= 0) begin
      sel <= SEL_W'(first);
      vld <= 1'b1;
    end else begin
      sel <= IDLE;
      vld <= 1'b0;
    end
  end

  // R6: no grant means idle code
  a_r6_idle_code: assert property (@(posedge clk) disable iff (rst)
    !vld |-> (sel == IDLE));
  // R6: closed band never grants
  a_r6_closed: assert property (@(posedge clk) disable iff (rst)
    !band_act |=> !vld);
  // R5: eligible priority input wins next edge
  a_r5_prio_win: assert property (@(posedge clk) disable iff (rst)
    (band_act && !band_start && !band_stop && prio_hit)
      |=> (vld && sel == {1'b0, $past(prio)}));
  // R4: a granted input that stays eligible keeps the output
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (band_act && !band_start && !band_stop && !prio_hit && held_ok)
      |=> $stable(sel));
endmodule

// File: rtl/bandsw_stamp.sv
module bandsw_stamp #(
  parameter int N    = 4,
  parameter int TS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [N-1:0]      ev,
  input  logic [TS_W-1:0]   now,
  output logic [N*TS_W-1:0] ts,
  output logic [N-1:0]      seen
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        ts[i*TS_W +: TS_W] <= '0;
        seen[i]            <= 1'b0;
      end else if (en && ev[i] && !seen[i]) begin
        ts[i*TS_W +: TS_W] <= now;
        seen[i]            <= 1'b1;
      end
    end

    // R8 / R9: a captured stamp stays frozen until cleared
    a_r8_r9_frozen: assert property (@(posedge clk) disable iff (rst)
      (seen[i] && !clr) |=> ($stable(ts[i*TS_W +: TS_W]) && seen[i]));
  end
endmodule

// File: rtl/bandsw_ctrl.sv
module bandsw_ctrl #(
  parameter int N_PORTS = 4,
  parameter int TS_W    = 16,
  localparam int IDX_W  = $clog2(N_PORTS),
  localparam int SEL_W  = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [TS_W-1:0]         cyc_len,
  input  logic [TS_W-1:0]         band_begin,
  input  logic [TS_W-1:0]         band_end,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_port,
  input  logic [N_PORTS-1:0]      cfg_mask,
  input  logic [IDX_W-1:0]        cfg_prio,
  input  logic                    cfg_prio_en,
  input  logic [N_PORTS-1:0]      busy_in,
  output logic                    band_active,
  output logic [N_PORTS-1:0]      out_en,
  output logic [N_PORTS*SEL_W-1:0] sel_out,
  output logic [N_PORTS-1:0]      sel_vld,
  output logic [N_PORTS-1:0]      resend_req,
  output logic [TS_W-1:0]         cyc_now,
  output logic [N_PORTS*TS_W-1:0] arr_ts,
  output logic [N_PORTS-1:0]      arr_vld,
  output logic [N_PORTS*TS_W-1:0] dep_ts,
  output logic [N_PORTS-1:0]      dep_vld
);
  logic band_start, band_stop;

  logic [N_PORTS-1:0] stg_mask [N_PORTS];
  logic [IDX_W-1:0]   stg_prio [N_PORTS];
  logic [N_PORTS-1:0] stg_pen;
  logic [N_PORTS-1:0] act_mask [N_PORTS];
  logic [IDX_W-1:0]   act_prio [N_PORTS];
  logic [N_PORTS-1:0] act_pen;
  logic [N_PORTS-1:0] pre_v    [N_PORTS];

  bandsw_clock #(.TS_W(TS_W)) u_clock (
    .clk        (clk),
    .rst        (rst),
    .cyc_len    (cyc_len),
    .band_begin (band_begin),
    .band_end   (band_end),
    .cnt        (cyc_now),
    .band_act   (band_active),
    .band_start (band_start),
    .band_stop  (band_stop)
  );

  // Staging written by host; active copy taken at band opening.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int o = 0; o < N_PORTS; o++) begin
        stg_mask[o] <= '0;
        stg_prio[o] <= '0;
        act_mask[o] <= '0;
        act_prio[o] <= '0;
      end
      stg_pen <= '0;
      act_pen <= '0;
      out_en  <= '0;
    end else begin
      if (cfg_we) begin
        stg_mask[cfg_port] <= cfg_mask;
        stg_prio[cfg_port] <= cfg_prio;
        stg_pen[cfg_port]  <= cfg_prio_en;
      end
      if (band_start) begin
        act_mask <= stg_mask;
        act_prio <= stg_prio;
        act_pen  <= stg_pen;
        for (int o = 0; o < N_PORTS; o++) out_en[o] <= |stg_mask[o];
      end else if (band_stop) begin
        out_en <= '0;
      end
    end
  end

  for (genvar o = 0; o < N_PORTS; o++) begin : g_out
    bandsw_outarb #(.N(N_PORTS), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_arb (
      .clk        (clk),
      .rst        (rst),
      .band_act   (band_active),
      .band_start (band_start),
      .band_stop  (band_stop),
      .busy       (busy_in),
      .mask       (act_mask[o]),
      .prio       (act_prio[o]),
      .prio_en    (act_pen[o]),
      .sel        (sel_out[o*SEL_W +: SEL_W]),
      .vld        (sel_vld[o]),
      .preempt    (pre_v[o])
    );
  end

  always_comb begin
    resend_req = '0;
    for (int o = 0; o < N_PORTS; o++) resend_req = resend_req | pre_v[o];
  end

  bandsw_stamp #(.N(N_PORTS), .TS_W(TS_W)) u_arrival (
    .clk  (clk),
    .rst  (rst),
    .clr  (band_start),
    .en   (band_active),
    .ev   (busy_in),
    .now  (cyc_now),
    .ts   (arr_ts),
    .seen (arr_vld)
  );

  bandsw_stamp #(.N(N_PORTS), .TS_W(TS_W)) u_departure (
    .clk  (clk),
    .rst  (rst),
    .clr  (band_start),
    .en   (band_active),
    .ev   (sel_vld),
    .now  (cyc_now),
    .ts   (dep_ts),
    .seen (dep_vld)
  );

  // R2: an enabled output implies an open band
  a_r2_out_en: assert property (@(posedge clk) disable iff (rst)
    (out_en != '0) |-> band_active);
  // R6: no output grants while the band is closed
  a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
    !band_active |-> (sel_vld == '0));
endmodule

// File: tb/tb_bandsw_ctrl.sv
`timescale 1ns/1ps
module tb_bandsw_ctrl;
  localparam int N = 4;
  localparam int TW = 16;
  localparam int IW = 2;
  localparam int SW = 3;
  localparam int C = 24;
  localparam int BEG = 6;
  localparam int FIN = 22;

  // {busy[3:0], sel0, sel1, sel3, vld{o0,o1,o3}, resend[3:0]}
  localparam logic [19:0] VEC [7] = '{
    {4'b0000, 3'd7, 3'd7, 3'd7, 3'b000, 4'b0000},
    {4'b0110, 3'd1, 3'd1, 3'd1, 3'b111, 4'b0000},
    {4'b0111, 3'd1, 3'd1, 3'd1, 3'b111, 4'b0000},
    {4'b0101, 3'd0, 3'd2, 3'd7, 3'b110, 4'b0000},
    {4'b1101, 3'd3, 3'd2, 3'd3, 3'b111, 4'b0001},
    {4'b0101, 3'd0, 3'd2, 3'd7, 3'b110, 4'b0000},
    {4'b0001, 3'd0, 3'd7, 3'd7, 3'b100, 4'b0000}
  };

  logic clk = 0, rst = 1;
  logic [TW-1:0] cyc_len = TW'(C), band_begin = TW'(BEG), band_end = TW'(FIN);
  logic cfg_we = 0, cfg_prio_en = 0;
  logic [IW-1:0] cfg_port = 0, cfg_prio = 0;
  logic [N-1:0] cfg_mask = 0, busy_in = 0;
  logic band_active;
  logic [N-1:0] out_en, sel_vld, resend_req, arr_vld, dep_vld;
  logic [N*SW-1:0] sel_out;
  logic [TW-1:0] cyc_now;
  logic [N*TW-1:0] arr_ts, dep_ts;

  int checks = 0, fails = 0, cnt_m = 0, cnt_bad = 0;
  int cpre [7];
  bit done = 0;

  always #2 clk = ~clk;

  bandsw_ctrl #(.N_PORTS(N), .TS_W(TW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cnt_m = (cnt_m == C - 1) ? 0 : cnt_m + 1;
    if (int'(cyc_now) != cnt_m) cnt_bad++;
  endtask

  task automatic wr(input int port, input logic [N-1:0] m, input int p, input bit pe);
    cfg_port = IW'(port); cfg_mask = m; cfg_prio = IW'(p); cfg_prio_en = pe; cfg_we = 1;
    tick();
    cfg_we = 0;
  endtask

  function automatic int selv(input int o);
    return int'(sel_out[o*SW +: SW]);
  endfunction
  function automatic int arrv(input int i);
    return int'(arr_ts[i*TW +: TW]);
  endfunction
  function automatic int depv(input int i);
    return int'(dep_ts[i*TW +: TW]);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // Reset state (R1, R6)
    chk(cyc_now == 0, "R1 reset count", int'(cyc_now), 0);
    chk(sel_out == '1 && sel_vld == 0, "R6 reset idle", int'(sel_out), 4095);
    chk(band_active == 0 && arr_vld == 0, "R2 reset closed", int'(band_active), 0);

    wr(0, 4'b1111, 3, 1);
    wr(1, 4'b0110, 0, 0);
    wr(3, 4'b1010, 1, 1);
    while (cnt_m != BEG + 1) tick();
    chk(band_active == 1, "R2 band opens", int'(band_active), 1);
    chk(out_en == 4'b1011, "R2 out_en from masks", int'(out_en), 11);

    // Vector table walk (R4, R5, R6, R7)
    for (int k = 0; k < 7; k++) begin
      busy_in = VEC[k][19:16];
      cpre[k] = cnt_m;
      tick();
      chk(selv(0) == int'(VEC[k][15:13]), $sformatf("R4/R5 v%0d out0", k), selv(0), int'(VEC[k][15:13]));
      chk(selv(1) == int'(VEC[k][12:10]), $sformatf("R4 v%0d out1", k), selv(1), int'(VEC[k][12:10]));
      chk(selv(3) == int'(VEC[k][9:7]), $sformatf("R5 v%0d out3", k), selv(3), int'(VEC[k][9:7]));
      chk(selv(2) == 7 && !sel_vld[2], $sformatf("R6 v%0d out2 idle", k), selv(2), 7);
      chk({sel_vld[0], sel_vld[1], sel_vld[3]} == VEC[k][6:4], $sformatf("R7 v%0d valid", k),
          int'({sel_vld[0], sel_vld[1], sel_vld[3]}), int'(VEC[k][6:4]));
      chk(resend_req == VEC[k][3:0], $sformatf("R5 v%0d resend", k), int'(resend_req), int'(VEC[k][3:0]));
    end

    // Timestamps (R8, R9)
    chk(arr_vld == 4'b1111, "R8 arrivals seen", int'(arr_vld), 15);
    chk(arrv(1) == cpre[1] && arrv(2) == cpre[1], "R8 arr in1/in2", arrv(1), cpre[1]);
    chk(arrv(0) == cpre[2], "R8 arr in0", arrv(0), cpre[2]);
    chk(arrv(3) == cpre[4], "R8 arr in3", arrv(3), cpre[4]);
    chk(dep_vld == 4'b1011, "R9 departures seen", int'(dep_vld), 11);
    chk(depv(0) == cpre[2] && depv(1) == cpre[2] && depv(3) == cpre[2], "R9 dep times", depv(3), cpre[2]);

    // Mid-band staging write must not disturb grants (R3)
    wr(0, 4'b0000, 0, 0);
    tick();
    chk(sel_vld[0] == 1 && selv(0) == 0, "R3 mid-band write ignored", selv(0), 0);

    while (cnt_m != FIN) tick();
    chk(band_active == 1 && sel_vld[0] == 1, "R2 open before end", int'(band_active), 1);
    tick();
    chk(band_active == 0 && out_en == 0, "R2 band closes", int'(out_en), 0);
    chk(sel_vld == 0 && sel_out == '1, "R6 idle at close", int'(sel_out), 4095);

    // Outside band: busy ignored (R6, R8)
    busy_in = 4'b1111;
    tick(); tick();
    chk(sel_vld == 0, "R6 busy ignored outside band", int'(sel_vld), 0);
    chk(arrv(1) == cpre[1], "R8 no recapture outside band", arrv(1), cpre[1]);

    wr(1, 4'b1000, 0, 0);
    busy_in = 4'b1000;
    while (cnt_m != 0) tick();
    chk(cyc_now == 0, "R1 wrap to zero", int'(cyc_now), 0);
    while (cnt_m != BEG + 1) tick();
    chk(arr_vld == 0 && dep_vld == 0, "R8/R9 cleared at open", int'(arr_vld), 0);
    chk(out_en == 4'b1010, "R3 staged masks applied", int'(out_en), 10);
    tick();
    chk(arr_vld == 4'b1000 && arrv(3) == BEG + 1, "R8 second band arrival", arrv(3), BEG + 1);
    chk(selv(1) == 3 && sel_vld == 4'b1010, "R3 new mask routes", selv(1), 3);
    tick();
    chk(dep_vld == 4'b1010 && depv(1) == BEG + 2, "R9 second band departure", depv(1), BEG + 2);
    chk(cnt_bad == 0, "R1 counter followed model", cnt_bad, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule